// File: doc/BRIEF.md
# Packet FIFO Write Endpoint

This block is the fill side of a slave FIFO that an external master writes synchronously on one interface clock. Each cycle the master presents a chip select, a write strobe, an endpoint address, a data word and a packet-end strobe. Accepted words go into the addressed endpoint's circular buffer. Each endpoint keeps its own open-packet count.

A packet closes in one of two ways. The first is automatic, when auto mode is on and the open count reaches a programmed length. The second is manual, on a packet-end strobe. A packet-end strobe may arrive on the same edge as the last data word or on any later cycle.

Each closed packet pushes one `{endpoint, length}` entry into a shared length queue. The queue is presented on a valid/ready port. Popping an entry releases that packet's words from its endpoint buffer, and this stands in for the host-side drain. A combinational peek port reads the stored words from the head of any endpoint. Per-endpoint full and empty flags are registered state and change after the edge that caused them.

Top module: `pkt_fifo_wr`

## Requirements
- R1: A word is written only on a rising edge where `cs_i` and `wr_i` are both 1. It goes to the endpoint given by `addr_i` on that edge. The word at head offset k of endpoint e is visible on `peek_data_o` when `peek_ep_i`=e and `peek_idx_i`=k.
- R2: While `cs_i` and `wr_i` stay 1, one word is written on every rising edge (burst). Words keep their arrival order.
- R3: `empty_o[e]` is 1 exactly when endpoint e holds no words. `full_o[e]` is 1 when endpoint e holds DEPTH words or when the length queue holds LQ_DEPTH entries. Both flags change after the edge that wrote or released the words.
- R4: A write to an endpoint whose `full_o` bit is 1 is dropped. The dropped word is neither stored nor counted in the packet length.
- R5: A packet-end strobe on the same edge as an accepted write commits a packet that includes that word.
- R6: A packet-end strobe on a cycle with no write commits the words accumulated so far. With no words pending, it commits a zero-length packet.
- R7: With `auto_en_i`=1, the packet is committed on the edge where an accepted write makes the open count equal `auto_len_i` (nonzero).
- R8: A packet-end strobe on the same edge as the write that completes an auto packet produces only that one commit. A packet end on a later edge starts a new packet, for example a one-word packet.
- R9: Each endpoint address has its own open-packet count and storage. Activity on one endpoint leaves the other's count, words and flags unchanged.
- R10: Committed packets appear on `len_valid_o`/`len_ep_o`/`len_o` in commit order, one entry per packet. An entry is held stable until `len_ready_i` is 1. Popping an entry frees that packet's words from its endpoint.
- R11: A packet-end strobe is ignored when `cs_i` is 0 or when the length queue is full. In both cases no entry is pushed and the open count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe |
| pkt_end_i | input | 1 | Packet-end strobe |
| addr_i | input | EP_W | Endpoint select |
| data_i | input | DATA_W | Write data |
| auto_en_i | input | 1 | Enable automatic commit |
| auto_len_i | input | CNT_W | Automatic packet length |
| full_o | output | NUM_EP | Per-endpoint full flag |
| empty_o | output | NUM_EP | Per-endpoint empty flag |
| len_valid_o | output | 1 | Length entry available |
| len_ready_i | input | 1 | Consumer takes the entry |
| len_ep_o | output | EP_W | Endpoint of the entry |
| len_o | output | CNT_W | Packet length in words |
| peek_ep_i | input | EP_W | Endpoint to read |
| peek_idx_i | input | PTR_W | Offset from that endpoint's head |
| peek_data_o | output | DATA_W | Stored word at that offset |

## Verification
The assertions assume `auto_len_i` does not fall below an endpoint's open count while auto mode is on. They also assume the consumer takes only entries that are valid. The stimulus changes `auto_len_i` and `auto_en_i` only when every open count is zero. It raises `len_ready_i` only in dedicated pop cycles, after it has already seen `len_valid_o`. Inputs are driven on the falling edge, so every strobe combination the checks rely on is sampled whole on a single rising edge.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  // width of a field holding 0..n-1, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  // width of a field holding 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pfw_ep_buf.sv
module pfw_ep_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = pfw_pkg::idx_w(DEPTH),
  localparam int CNT_W = pfw_pkg::cnt_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              free_i,
  input  logic [CNT_W-1:0]  free_len_i,
  input  logic [PTR_W-1:0]  peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic [CNT_W-1:0]  open_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  occ_q, open_q;
  logic [CNT_W-1:0]  sub_len;

  assign sub_len = free_i ? free_len_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      open_q   <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (free_i) rd_ptr_q <= rd_ptr_q + PTR_W'(free_len_i);
      occ_q  <= occ_q + CNT_W'(wr_i) - sub_len;
      open_q <= commit_i ? '0 : open_q + CNT_W'(wr_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign peek_data_o = mem_q[rd_ptr_q + peek_idx_i];
  assign occ_o  = occ_q;
  assign open_o = open_q;

  p_occ_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CNT_W'(DEPTH));
  p_open_in_occ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q <= occ_q);
  p_burst_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !free_i) |=> occ_q == $past(occ_q) + CNT_W'(1));
  p_commit_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> open_q == '0);
endmodule

// File: rtl/pfw_len_queue.sv
module pfw_len_queue #(
  parameter int ENT_W = 5,
  parameter int DEPTH = 4,
  localparam int PTR_W = pfw_pkg::idx_w(DEPTH),
  localparam int CNT_W = pfw_pkg::cnt_w(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [ENT_W-1:0] ent_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [ENT_W-1:0] ent_o
);
  logic [ENT_W-1:0] q_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign pop     = valid_o && ready_i;
  assign valid_o = cnt_q != '0;
  assign full_o  = cnt_q == CNT_W'(DEPTH);
  assign ent_o   = q_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
      if (pop)    rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) q_q[wp_q] <= ent_i;
  end

  p_no_push_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_hold_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(ent_o)));
endmodule

// File: rtl/pkt_fifo_wr.sv
module pkt_fifo_wr #(
  parameter int NUM_EP   = 2,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int LQ_DEPTH = 4,
  localparam int EP_W  = pfw_pkg::idx_w(NUM_EP),
  localparam int PTR_W = pfw_pkg::idx_w(DEPTH),
  localparam int CNT_W = pfw_pkg::cnt_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              pkt_end_i,
  input  logic [EP_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              auto_en_i,
  input  logic [CNT_W-1:0]  auto_len_i,
  output logic [NUM_EP-1:0] full_o,
  output logic [NUM_EP-1:0] empty_o,
  output logic              len_valid_o,
  input  logic              len_ready_i,
  output logic [EP_W-1:0]   len_ep_o,
  output logic [CNT_W-1:0]  len_o,
  input  logic [EP_W-1:0]   peek_ep_i,
  input  logic [PTR_W-1:0]  peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o
);
  localparam int ENT_W = EP_W + CNT_W;

  logic [CNT_W-1:0]  occ  [NUM_EP];
  logic [CNT_W-1:0]  open [NUM_EP];
  logic [DATA_W-1:0] peek [NUM_EP];
  logic              lq_full, wr_ok, auto_hit, pe_ok, commit, pop;
  logic [CNT_W-1:0]  cnt_next;

  assign wr_ok    = cs_i && wr_i && !full_o[addr_i];
  assign cnt_next = open[addr_i] + CNT_W'(wr_ok);
  assign auto_hit = wr_ok && auto_en_i && (cnt_next == auto_len_i);
  assign pe_ok    = cs_i && pkt_end_i && !lq_full;
  // auto and manual on one edge close the same packet once
  assign commit   = auto_hit || pe_ok;
  assign pop      = len_valid_o && len_ready_i;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic sel;
    assign sel = addr_i == EP_W'(e);
    pfw_ep_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_ok && sel),
      .data_i     (data_i),
      .commit_i   (commit && sel),
      .free_i     (pop && (len_ep_o == EP_W'(e))),
      .free_len_i (len_o),
      .peek_idx_i (peek_idx_i),
      .peek_data_o(peek[e]),
      .occ_o      (occ[e]),
      .open_o     (open[e])
    );
    assign full_o[e]  = (occ[e] == CNT_W'(DEPTH)) || lq_full;
    assign empty_o[e] = occ[e] == '0;
  end

  assign peek_data_o = peek[peek_ep_i];

  pfw_len_queue #(.ENT_W(ENT_W), .DEPTH(LQ_DEPTH)) i_lq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (commit),
    .ent_i  ({addr_i, cnt_next}),
    .full_o (lq_full),
    .valid_o(len_valid_o),
    .ready_i(len_ready_i),
    .ent_o  ({len_ep_o, len_o})
  );

  p_no_overrun_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && full_o[addr_i]) |=> $stable(occ[$past(addr_i)]) || $past(pop));
  p_auto_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_hit && !pop) |=> len_valid_o);
endmodule

// File: tb/test_pkt_fifo_wr.sv
module test_pkt_fifo_wr;
  localparam int NUM_EP = 2, DATA_W = 8, DEPTH = 8, LQ = 4;
  localparam int EP_W = 1, PTR_W = 3, CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cs = 0, wr = 0, pe = 0, aen = 0, rdy = 0;
  logic [EP_W-1:0] addr = '0, pk_ep = '0, l_ep;
  logic [DATA_W-1:0] din = '0, pk_d;
  logic [CNT_W-1:0] alen = '0, l_len;
  logic [PTR_W-1:0] pk_idx = '0;
  logic [NUM_EP-1:0] full, empty;
  logic l_val;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_fifo_wr #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .DEPTH(DEPTH), .LQ_DEPTH(LQ)) i_pkt_fifo_wr (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .pkt_end_i(pe),
    .addr_i(addr), .data_i(din), .auto_en_i(aen), .auto_len_i(alen),
    .full_o(full), .empty_o(empty), .len_valid_o(l_val), .len_ready_i(rdy),
    .len_ep_o(l_ep), .len_o(l_len), .peek_ep_i(pk_ep), .peek_idx_i(pk_idx),
    .peek_data_o(pk_d));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic cyc(input bit c, input bit w, input bit p, input int a, input int d);
    @(negedge clk);
    cs = c; wr = w; pe = p; addr = EP_W'(a); din = DATA_W'(d); rdy = 0;
    @(posedge clk); #1;
    cs = 0; wr = 0; pe = 0;
  endtask

  task automatic pop_chk(input string req, input int ep, input int len);
    chk({req, " valid"}, int'(l_val), 1);
    chk({req, " ep"}, int'(l_ep), ep);
    chk({req, " len"}, int'(l_len), len);
    @(negedge clk); rdy = 1;
    @(posedge clk); #1; rdy = 0;
  endtask

  task automatic peek_chk(input string req, input int ep, input int idx, input int exp);
    pk_ep = EP_W'(ep); pk_idx = PTR_W'(idx); #0.5;
    chk(req, int'(pk_d), exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #7 rst_n = 1;
    @(posedge clk); #1;
    chk("R3 reset empty", int'(empty), 3);
    chk("R3 reset full", int'(full), 0);
    chk("R10 reset valid", int'(l_val), 0);

    // R1: only cs&wr writes
    cyc(1, 0, 0, 0, 8'h11);
    cyc(0, 1, 0, 0, 8'h22);
    chk("R1 no write without both strobes", int'(empty), 3);
    cyc(1, 1, 0, 0, 8'hA5);
    chk("R1 write lands", int'(empty[0]), 0);
    chk("R9 other ep untouched", int'(empty[1]), 1);
    peek_chk("R1 data", 0, 0, 8'hA5);

    // R2 burst, R5 packet end with last word
    cyc(1, 1, 0, 0, 8'h01);
    cyc(1, 1, 0, 0, 8'h02);
    cyc(1, 1, 1, 0, 8'h03);
    for (int k = 1; k < 4; k++) peek_chk("R2 burst order", 0, k, k);
    pop_chk("R5 same-edge commit", 0, 4);
    chk("R10 pop frees", int'(empty[0]), 1);
    chk("R10 queue drained", int'(l_val), 0);

    // R9 interleaved endpoints, R6 later packet end
    cyc(1, 1, 0, 1, 8'h40);
    cyc(1, 1, 0, 0, 8'h50);
    cyc(1, 1, 0, 1, 8'h41);
    cyc(1, 1, 0, 0, 8'h51);
    cyc(1, 1, 0, 0, 8'h52);
    cyc(1, 0, 1, 1, 0);
    cyc(1, 0, 1, 0, 0);
    peek_chk("R9 ep1 word", 1, 1, 8'h41);
    peek_chk("R9 ep0 word", 0, 2, 8'h52);
    pop_chk("R6 ep1 later commit", 1, 2);
    pop_chk("R9 ep0 count", 0, 3);
    cyc(1, 0, 1, 1, 0);
    pop_chk("R6 zero-length", 1, 0);

    // R11 packet end without chip select
    cyc(1, 1, 0, 0, 8'h77);
    cyc(0, 0, 1, 0, 0);
    chk("R11 no cs no commit", int'(l_val), 0);
    cyc(1, 0, 1, 0, 0);
    pop_chk("R11 count kept", 0, 1);

    // R7 auto commit
    aen = 1; alen = 4'd3;
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, 0, k);
    pop_chk("R7 auto first", 0, 3);
    pop_chk("R7 auto second", 0, 3);
    chk("R7 nothing open", int'(l_val), 0);

    // R8 same-edge packet end with auto completion, then one-word packet
    cyc(1, 1, 0, 1, 1);
    cyc(1, 1, 0, 1, 2);
    cyc(1, 1, 1, 1, 3);
    cyc(1, 1, 1, 1, 4);
    pop_chk("R8 auto single", 1, 3);
    pop_chk("R8 one-word", 1, 1);
    chk("R8 no extra", int'(l_val), 0);
    aen = 0; alen = '0;

    // R3 sweep of fill level, R4 overflow drop
    for (int n = 1; n <= DEPTH; n++) begin
      cyc(1, 1, 0, 1, n * 17 + 3);
      chk("R3 sweep empty", int'(empty[1]), 0);
      chk("R3 sweep full", int'(full[1]), (n == DEPTH) ? 1 : 0);
      chk("R9 sweep other", int'(full[0]), 0);
    end
    cyc(1, 1, 0, 1, 8'hEE);
    peek_chk("R4 last kept", 1, DEPTH - 1, DEPTH * 17 + 3);
    peek_chk("R4 head kept", 1, 0, 20);
    cyc(1, 1, 1, 1, 8'hEF);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 stall hold len", int'(l_len), DEPTH);
    end
    pop_chk("R4 dropped not counted", 1, DEPTH);
    chk("R3 release", int'(empty[1]), 1);

    // R11 length queue full
    for (int k = 0; k < LQ; k++) cyc(1, 0, 1, 1, 0);
    chk("R3 queue full flags", int'(full), 3);
    cyc(1, 0, 1, 1, 0);
    cyc(1, 1, 0, 0, 8'h99);
    chk("R11 write dropped", int'(empty[0]), 1);
    for (int k = 0; k < LQ; k++) pop_chk("R11 queued", 1, 0);
    chk("R11 ignored end", int'(l_val), 0);
    chk("R3 flags clear", int'(full), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule